// File: doc/BRIEF.md
# Three-Channel Interval Timer Register Interface

This block gives a host processor byte-wide access to three independent 16-bit down counters. The host sees four addresses. Each counter has its own data port, and a shared control port takes control words. A control word names a counter and either sets how that counter's bytes are reached (low byte only, high byte only, or low byte then high byte) or asks for a snapshot of its live count. Reload values are built from one or two data-port writes. Reads return either the live count or the frozen snapshot, one byte per access.

Each counter decrements once per pulse on its own tick input. When it expires it reloads from its stored value and raises a one-cycle terminal-count pulse. The counting-mode and BCD fields of a control word are stored and can be read back, but counting is always plain binary reload counting.

Top module: `ctr3_host_if`

## Requirements
- R1: After reset every count and reload value is 0, no terminal-count pulse is active, every counter uses low-then-high access (field value 11) with mode 0 and BCD 0, and a read of the control port returns 0x30.
- R2: Offsets 0, 1 and 2 are the data ports of counters 0, 1 and 2, and offset 3 is the control port. Control-word bits 7:6 pick the counter (00, 01, 10). The value 11 in bits 7:6 makes the whole word have no effect on any counter or on the control readback.
- R3: Access field bits 5:4 = 11 selects low-then-high access. Each counter keeps separate write and read byte pointers. A control word with a nonzero access field resets both pointers to the low byte, and each data write or read toggles its own pointer.
- R4: Access field 01 reads and writes the low byte only, and 10 reads and writes the high byte only. A write in either mode sets the other byte of the reload value to 0.
- R5: A reload value takes effect only on its final byte (the only write in 01/10 mode, the high-byte write in 11 mode). The count is loaded with the new reload value on that write's clock edge.
- R6: Each tick pulse decrements the count by one, and a count of 0 steps to 0xFFFF. A tick seen while the count is 1 instead reloads the count from the stored reload value and drives that counter's terminal-count output high for exactly the next cycle.
- R7: Access field 00 is a latch command. It copies the live count into a snapshot, and the counter's data-port reads then return snapshot bytes while counting goes on.
- R8: A snapshot is held until every byte of the current access mode has been read (one read in 01/10 mode, low then high in 11 mode). A latch command resets the read pointer to the low byte. A latch command issued while a snapshot is held is ignored. A control word with a nonzero access field drops the snapshot.
- R9: A data-port write while a snapshot is held is an ordinary reload write and keeps the snapshot.
- R10: Control-word bits 3:1 (mode) and bit 0 (BCD) are stored per counter. A control-port read returns {counter index, access, mode, BCD} of the counter last named by a control word, in the control-word bit positions. Counting stays binary whatever these fields hold.
- R11: Data-port and control-port reads never change any count; without a tick or reload the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_cs_i | input | 1 | Chip select for a bus access |
| bus_wr_i | input | 1 | Write strobe, one cycle per byte |
| bus_rd_i | input | 1 | Read strobe, one cycle per byte |
| bus_addr_i | input | 2 | Port offset: 0..2 data, 3 control |
| bus_wdata_i | input | 8 | Write data byte |
| bus_rdata_o | output | 8 | Read data byte, valid in the cycle of the read strobe |
| cnt_tick_i | input | 3 | Per-counter count-enable pulses |
| tc_pulse_o | output | 3 | Per-counter one-cycle terminal-count pulses |

## Verification
Directed sequences try the main function with split two-byte writes, where a read between the bytes shows whether the reload takes effect too early, and with single-byte writes in each half, which show whether the other byte is zeroed. Latch commands are issued during counting, repeated while a snapshot is held, and combined with data writes, which separates frozen from live reads and shows when the snapshot is released. Counts started at 1, at small values and at 0 show the reload, the terminal pulse and the wrap. Long random runs of control words, byte accesses and tick pulses on all three counters then expose pointer and snapshot interactions that the directed cases do not reach.

// File: rtl/ctr3_pkg.sv
package ctr3_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    ACC_SNAP = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_PAIR = 2'b11
  } acc_e;

  typedef struct packed {
    logic [1:0] chan;
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } ctl_word_t;

  // Reload value produced by a final-byte write.
  function automatic logic [CNT_W-1:0] f_assemble(
    input logic [1:0] acc, input logic [BYTE_W-1:0] lo_held,
    input logic [BYTE_W-1:0] d);
    case (acc)
      ACC_LO:  return {{BYTE_W{1'b0}}, d};
      ACC_HI:  return {d, {BYTE_W{1'b0}}};
      default: return {d, lo_held};
    endcase
  endfunction

  // Byte presented on a data-port read.
  function automatic logic [BYTE_W-1:0] f_pick(
    input logic [CNT_W-1:0] v, input logic [1:0] acc, input logic hi_ptr);
    case (acc)
      ACC_LO:  return v[BYTE_W-1:0];
      ACC_HI:  return v[CNT_W-1:BYTE_W];
      default: return hi_ptr ? v[CNT_W-1:BYTE_W] : v[BYTE_W-1:0];
    endcase
  endfunction

  // True when this access completes the transfer for the access mode.
  function automatic logic f_is_last(input logic [1:0] acc, input logic ptr);
    return (acc != ACC_PAIR) || ptr;
  endfunction

  // Count after one tick.
  function automatic logic [CNT_W-1:0] f_step(
    input logic [CNT_W-1:0] cnt, input logic [CNT_W-1:0] rld);
    return (cnt == CNT_W'(1)) ? rld : cnt - CNT_W'(1);
  endfunction

endpackage

// File: rtl/ctr3_bus_decode.sv
module ctr3_bus_decode
  import ctr3_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int AW     = 2
) (
  input  logic                cs_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  output logic [NUM_CH-1:0]   ctl_hit_o,
  output logic [NUM_CH-1:0]   data_wr_o,
  output logic [NUM_CH-1:0]   data_rd_o,
  output logic [1:0]          cw_acc_o,
  output logic [2:0]          cw_mode_o,
  output logic                cw_bcd_o
);
  localparam int CTL_ADDR = NUM_CH;

  ctl_word_t cw;
  logic      ctl_wr;

  always_comb begin
    cw        = ctl_word_t'(wdata_i);
    cw_acc_o  = cw.acc;
    cw_mode_o = cw.mode;
    cw_bcd_o  = cw.bcd;
    ctl_wr    = cs_i && wr_i && (addr_i == AW'(CTL_ADDR));
    for (int c = 0; c < NUM_CH; c++) begin
      ctl_hit_o[c] = ctl_wr && (cw.chan == 2'(c));
      data_wr_o[c] = cs_i && wr_i && (addr_i == AW'(c));
      data_rd_o[c] = cs_i && rd_i && (addr_i == AW'(c));
    end
  end

endmodule

// File: rtl/ctr3_byte_seq.sv
module ctr3_byte_seq
  import ctr3_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctl_hit_i,
  input  logic [1:0]         cw_acc_i,
  input  logic [2:0]         cw_mode_i,
  input  logic               cw_bcd_i,
  input  logic               data_wr_i,
  input  logic               data_rd_i,
  input  logic [BYTE_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]   live_i,
  output logic               load_o,
  output logic [CNT_W-1:0]   load_val_o,
  output logic [BYTE_W-1:0]  rd_byte_o,
  output logic [1:0]         acc_o,
  output logic [2:0]         mode_o,
  output logic               bcd_o,
  output logic               wr_hi_o,
  output logic               lpend_o,
  output logic [CNT_W-1:0]   lval_o
);
  logic [1:0]        acc_q;
  logic [2:0]        mode_q;
  logic              bcd_q;
  logic              wr_hi_q, rd_hi_q;
  logic [BYTE_W-1:0] lo_q;
  logic              lpend_q;
  logic [CNT_W-1:0]  lval_q;

  logic              set_mode, snap_req, rd_done;
  logic [CNT_W-1:0]  rd_src;

  always_comb begin
    set_mode   = ctl_hit_i && (cw_acc_i != ACC_SNAP);
    snap_req   = ctl_hit_i && (cw_acc_i == ACC_SNAP);
    load_o     = data_wr_i && f_is_last(acc_q, wr_hi_q);
    load_val_o = f_assemble(acc_q, lo_q, wdata_i);
    rd_src     = lpend_q ? lval_q : live_i;
    rd_byte_o  = f_pick(rd_src, acc_q, rd_hi_q);
    rd_done    = data_rd_i && f_is_last(acc_q, rd_hi_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= ACC_PAIR;
      mode_q  <= '0;
      bcd_q   <= 1'b0;
      wr_hi_q <= 1'b0;
      rd_hi_q <= 1'b0;
      lo_q    <= '0;
      lpend_q <= 1'b0;
      lval_q  <= '0;
    end else if (set_mode) begin
      acc_q   <= cw_acc_i;
      mode_q  <= cw_mode_i;
      bcd_q   <= cw_bcd_i;
      wr_hi_q <= 1'b0;
      rd_hi_q <= 1'b0;
      lpend_q <= 1'b0;
    end else if (snap_req) begin
      if (!lpend_q) begin
        lval_q  <= live_i;
        lpend_q <= 1'b1;
        rd_hi_q <= 1'b0;
      end
    end else begin
      if (data_wr_i && (acc_q == ACC_PAIR)) begin
        if (!wr_hi_q) lo_q <= wdata_i;
        wr_hi_q <= !wr_hi_q;
      end
      if (data_rd_i && (acc_q == ACC_PAIR)) rd_hi_q <= !rd_hi_q;
      if (rd_done) lpend_q <= 1'b0;
    end
  end

  assign acc_o   = acc_q;
  assign mode_o  = mode_q;
  assign bcd_o   = bcd_q;
  assign wr_hi_o = wr_hi_q;
  assign lpend_o = lpend_q;
  assign lval_o  = lval_q;

endmodule

// File: rtl/ctr3_down_cnt.sv
module ctr3_down_cnt
  import ctr3_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             tc_o
);
  logic [CNT_W-1:0] cnt_q, rld_q;
  logic             tc_q;
  logic             expiring;

  assign expiring = tick_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rld_q <= '0;
      tc_q  <= 1'b0;
    end else if (load_i) begin
      rld_q <= load_val_i;
      cnt_q <= load_val_i;
      tc_q  <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= f_step(cnt_q, rld_q);
      tc_q  <= expiring;
    end else begin
      tc_q  <= 1'b0;
    end
  end

  assign count_o  = cnt_q;
  assign reload_o = rld_q;
  assign tc_o     = tc_q;

endmodule

// File: rtl/ctr3_host_if.sv
module ctr3_host_if
  import ctr3_pkg::*;
#(
  parameter int NUM_CH = 3,
  localparam int AW    = $clog2(NUM_CH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_cs_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  output logic [BYTE_W-1:0] bus_rdata_o,
  input  logic [NUM_CH-1:0] cnt_tick_i,
  output logic [NUM_CH-1:0] tc_pulse_o
);
  localparam int CTL_ADDR = NUM_CH;

  logic [NUM_CH-1:0]             ctl_hit, data_wr, data_rd;
  logic [1:0]                    cw_acc;
  logic [2:0]                    cw_mode;
  logic                          cw_bcd;

  logic [NUM_CH-1:0][CNT_W-1:0]  ch_count, ch_reload, ch_lval, ch_load_val;
  logic [NUM_CH-1:0][BYTE_W-1:0] ch_rbyte;
  logic [NUM_CH-1:0][1:0]        ch_acc;
  logic [NUM_CH-1:0][2:0]        ch_mode;
  logic [NUM_CH-1:0]             ch_bcd, ch_load, ch_lpend, ch_wr_hi;
  logic [1:0]                    last_sel_q;

  ctr3_bus_decode #(.NUM_CH(NUM_CH), .AW(AW)) dec_i (
    .cs_i      (bus_cs_i),
    .wr_i      (bus_wr_i),
    .rd_i      (bus_rd_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .ctl_hit_o (ctl_hit),
    .data_wr_o (data_wr),
    .data_rd_o (data_rd),
    .cw_acc_o  (cw_acc),
    .cw_mode_o (cw_mode),
    .cw_bcd_o  (cw_bcd)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ctr3_byte_seq seq_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ctl_hit_i  (ctl_hit[c]),
      .cw_acc_i   (cw_acc),
      .cw_mode_i  (cw_mode),
      .cw_bcd_i   (cw_bcd),
      .data_wr_i  (data_wr[c]),
      .data_rd_i  (data_rd[c]),
      .wdata_i    (bus_wdata_i),
      .live_i     (ch_count[c]),
      .load_o     (ch_load[c]),
      .load_val_o (ch_load_val[c]),
      .rd_byte_o  (ch_rbyte[c]),
      .acc_o      (ch_acc[c]),
      .mode_o     (ch_mode[c]),
      .bcd_o      (ch_bcd[c]),
      .wr_hi_o    (ch_wr_hi[c]),
      .lpend_o    (ch_lpend[c]),
      .lval_o     (ch_lval[c])
    );

    ctr3_down_cnt cnt_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (ch_load[c]),
      .load_val_i (ch_load_val[c]),
      .tick_i     (cnt_tick_i[c]),
      .count_o    (ch_count[c]),
      .reload_o   (ch_reload[c]),
      .tc_o       (tc_pulse_o[c])
    );
  end

  // Counter last named by an accepted control word.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_sel_q <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (ctl_hit[c]) last_sel_q <= 2'(c);
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr_i == AW'(c)) bus_rdata_o = ch_rbyte[c];
    end
    if (bus_addr_i == AW'(CTL_ADDR)) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (last_sel_q == 2'(c))
          bus_rdata_o = {last_sel_q, ch_acc[c], ch_mode[c], ch_bcd[c]};
      end
    end
  end

endmodule

// File: rtl/ctr3_chk.sv
module ctr3_chk
  import ctr3_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [NUM_CH-1:0]               cnt_tick_i,
  input logic [NUM_CH-1:0]               tc_pulse_o,
  input logic [NUM_CH-1:0][CNT_W-1:0]    ch_count,
  input logic [NUM_CH-1:0][CNT_W-1:0]    ch_reload,
  input logic [NUM_CH-1:0][CNT_W-1:0]    ch_lval,
  input logic [NUM_CH-1:0][1:0]          ch_acc,
  input logic [NUM_CH-1:0]               ch_load,
  input logic [NUM_CH-1:0]               ch_lpend,
  input logic [NUM_CH-1:0]               ch_wr_hi
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R6
    tc_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tc_pulse_o[c] |-> (ch_count[c] == ch_reload[c]));

    // R6
    tc_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tc_pulse_o[c] |-> ($past(cnt_tick_i[c]) && ($past(ch_count[c]) == CNT_W'(1))));

    // R6
    decrement_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(cnt_tick_i[c]) && !$past(ch_load[c]) && ($past(ch_count[c]) != CNT_W'(1)))
        |-> (ch_count[c] == $past(ch_count[c]) - CNT_W'(1)));

    // R11
    count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$past(cnt_tick_i[c]) && !$past(ch_load[c])) |-> $stable(ch_count[c]));

    // R7
    snap_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(ch_lpend[c]) && ch_lpend[c]) |-> $stable(ch_lval[c]));

    // R3
    wr_ptr_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_wr_hi[c] |-> (ch_acc[c] == 2'b11));
  end

endmodule

bind ctr3_host_if ctr3_chk #(.NUM_CH(NUM_CH)) chk_i (.*);

// File: tb/ctr3_host_if_tb.sv
`timescale 1ns/1ps
module ctr3_host_if_tb_top;
  localparam int NCH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic           cs = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0]     addr = '0;
  logic [7:0]     wdata = '0;
  logic [7:0]     rdata;
  logic [NCH-1:0] tick = '0;
  logic [NCH-1:0] tc;

  ctr3_host_if #(.NUM_CH(NCH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_cs_i(cs), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .cnt_tick_i(tick), .tc_pulse_o(tc)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference state derived from the requirements.
  logic [1:0]  m_acc  [NCH];
  logic [2:0]  m_mode [NCH];
  logic        m_bcd  [NCH];
  logic [15:0] m_rld  [NCH];
  logic [15:0] m_cnt  [NCH];
  logic [15:0] m_lval [NCH];
  logic [7:0]  m_lo   [NCH];
  logic        m_wrhi [NCH];
  logic        m_rdhi [NCH];
  logic        m_lp   [NCH];
  logic        m_tc   [NCH];
  logic [1:0]  m_last;

  task automatic m_reset();
    for (int c = 0; c < NCH; c++) begin
      m_acc[c] = 2'b11; m_mode[c] = '0; m_bcd[c] = 1'b0;
      m_rld[c] = '0; m_cnt[c] = '0; m_lval[c] = '0; m_lo[c] = '0;
      m_wrhi[c] = 1'b0; m_rdhi[c] = 1'b0; m_lp[c] = 1'b0; m_tc[c] = 1'b0;
    end
    m_last = '0;
  endtask

  function automatic logic [7:0] m_read(input logic [1:0] a);
    logic [15:0] src;
    if (a == 2'd3) return {m_last, m_acc[m_last], m_mode[m_last], m_bcd[m_last]};
    src = m_lp[a] ? m_lval[a] : m_cnt[a];
    case (m_acc[a])
      2'b01:   return src[7:0];
      2'b10:   return src[15:8];
      default: return m_rdhi[a] ? src[15:8] : src[7:0];
    endcase
  endfunction

  task automatic m_edge(input logic w, input logic r, input logic [1:0] a,
                        input logic [7:0] d, input logic [NCH-1:0] tk);
    logic hit, dw, dr, ld, last;
    logic [15:0] lv, oc;
    for (int c = 0; c < NCH; c++) begin
      hit = w && (a == 2'd3) && (d[7:6] == 2'(c));
      dw  = w && (a == 2'(c));
      dr  = r && (a == 2'(c));
      oc  = m_cnt[c];
      ld  = dw && ((m_acc[c] != 2'b11) || m_wrhi[c]);
      lv  = (m_acc[c] == 2'b01) ? {8'h00, d} :
            (m_acc[c] == 2'b10) ? {d, 8'h00} : {d, m_lo[c]};
      if (ld) begin
        m_rld[c] = lv; m_cnt[c] = lv; m_tc[c] = 1'b0;
      end else if (tk[c]) begin
        m_tc[c]  = (oc == 16'd1);
        m_cnt[c] = (oc == 16'd1) ? m_rld[c] : oc - 16'd1;
      end else begin
        m_tc[c] = 1'b0;
      end
      if (hit && (d[5:4] != 2'b00)) begin
        m_acc[c] = d[5:4]; m_mode[c] = d[3:1]; m_bcd[c] = d[0];
        m_wrhi[c] = 1'b0; m_rdhi[c] = 1'b0; m_lp[c] = 1'b0;
      end else if (hit) begin
        if (!m_lp[c]) begin
          m_lval[c] = oc; m_lp[c] = 1'b1; m_rdhi[c] = 1'b0;
        end
      end else begin
        if (dw && (m_acc[c] == 2'b11)) begin
          if (!m_wrhi[c]) m_lo[c] = d;
          m_wrhi[c] = !m_wrhi[c];
        end
        if (dr) begin
          last = (m_acc[c] != 2'b11) || m_rdhi[c];
          if (m_acc[c] == 2'b11) m_rdhi[c] = !m_rdhi[c];
          if (last) m_lp[c] = 1'b0;
        end
      end
    end
    if (w && (a == 2'd3) && (d[7:6] != 2'b11)) m_last = d[7:6];
  endtask

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive at the falling edge, check read data mid-cycle,
  // advance the reference after the rising edge, then check the pulses.
  task automatic step(input logic w, input logic r, input logic [1:0] a,
                      input logic [7:0] d, input logic [NCH-1:0] tk, input string tag);
    @(negedge clk);
    cs = w | r; wr = w; rd = r; addr = a; wdata = d; tick = tk;
    #1;
    if (r) chk({8'h00, rdata}, {8'h00, m_read(a)}, tag);
    @(posedge clk);
    #1;
    m_edge(w, r, a, d, tk);
    for (int c = 0; c < NCH; c++) chk({15'd0, tc[c]}, {15'd0, m_tc[c]}, "R6 tc");
  endtask

  task automatic wr_b(input logic [1:0] a, input logic [7:0] d);
    step(1'b1, 1'b0, a, d, '0, "");
  endtask
  task automatic rd_b(input logic [1:0] a, input string tag);
    step(1'b0, 1'b1, a, 8'h00, '0, tag);
  endtask
  task automatic tk_n(input logic [NCH-1:0] tk, input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, 8'h00, tk, "");
  endtask

  // Literal expected-value check on a read, beside the reference check.
  task automatic rd_lit(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cs = 1'b1; wr = 1'b0; rd = 1'b1; addr = a; wdata = '0; tick = '0;
    #1;
    chk({8'h00, rdata}, {8'h00, exp}, tag);
    chk({8'h00, rdata}, {8'h00, m_read(a)}, tag);
    @(posedge clk);
    #1;
    m_edge(1'b0, 1'b1, a, 8'h00, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] op, d;
    logic [1:0] a;
    logic [NCH-1:0] tk;
    string tag;
    m_reset();
    void'($urandom(32'd24681));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    rd_lit(2'd0, 8'h00, "R1 count0");
    rd_lit(2'd3, 8'h30, "R1 ctl");
    chk({13'd0, tc}, 16'd0, "R1 tc");

    // R3 / R5: split write, early read, then both bytes
    wr_b(2'd3, 8'h30);
    wr_b(2'd0, 8'h34);
    rd_lit(2'd0, 8'h00, "R5 no early load");
    rd_lit(2'd0, 8'h00, "R5 no early load hi");
    wr_b(2'd0, 8'h12);
    rd_lit(2'd0, 8'h34, "R3 low byte");
    rd_lit(2'd0, 8'h12, "R3 high byte");

    // R4 single-byte modes zero the other byte
    wr_b(2'd3, 8'h50);
    wr_b(2'd1, 8'hAB);
    rd_lit(2'd1, 8'hAB, "R4 low only");
    wr_b(2'd3, 8'h60);
    rd_lit(2'd1, 8'h00, "R4 high of low-only load");
    wr_b(2'd1, 8'h05);
    rd_lit(2'd1, 8'h05, "R4 high only");
    wr_b(2'd3, 8'h50);
    rd_lit(2'd1, 8'h00, "R4 low of high-only load");

    // R6 terminal count and wrap
    wr_b(2'd3, 8'h90);
    wr_b(2'd2, 8'h03);
    tk_n(3'b100, 3);
    rd_lit(2'd2, 8'h03, "R6 reloaded");
    wr_b(2'd2, 8'h00);
    tk_n(3'b100, 1);
    wr_b(2'd3, 8'hA0);
    rd_lit(2'd2, 8'hFF, "R6 wrap");

    // R7 / R8 latch during counting
    tk_n(3'b001, 4);
    wr_b(2'd3, 8'h00);
    tk_n(3'b001, 2);
    rd_lit(2'd0, 8'h30, "R7 frozen low");
    wr_b(2'd3, 8'h00);
    tk_n(3'b001, 1);
    rd_lit(2'd0, 8'h12, "R8 frozen high");
    rd_lit(2'd0, 8'h2D, "R8 released live");

    // R9 data write with snapshot held
    wr_b(2'd3, 8'h40);
    wr_b(2'd1, 8'h77);
    rd_b(2'd1, "R9 write during latch");
    wr_b(2'd3, 8'h40);
    rd_b(2'd1, "R9 live after release");

    // R2 counter field 11 ignored
    wr_b(2'd3, 8'hF6);
    rd_b(2'd3, "R2 ctl unchanged");
    rd_b(2'd0, "R2 ch0 unchanged");
    rd_b(2'd0, "R2 ch0 unchanged hi");

    // R10 mode and BCD readback, binary counting
    wr_b(2'd3, 8'h9B);
    rd_lit(2'd3, 8'h9B, "R10 ctl readback");
    wr_b(2'd2, 8'h10);
    tk_n(3'b100, 1);
    rd_lit(2'd2, 8'h0F, "R10 binary count");

    // R11 reads leave counting alone
    for (int i = 0; i < 4; i++) rd_b(2'd1, "R11 repeated read");
    rd_b(2'd3, "R11 ctl read");

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      op = 8'($urandom_range(0, 99));
      a  = 2'($urandom_range(0, 3));
      d  = 8'($urandom);
      tk = 3'($urandom) & 3'($urandom);
      if (op < 12) begin
        if (d[5:4] != 2'b00 && d[7:6] != 2'b11 && ($urandom_range(0, 3) == 0))
          d[5:4] = 2'b00;
        step(1'b1, 1'b0, 2'd3, d, tk, "");
      end else if (op < 40) begin
        if (a == 2'd3) a = 2'd0;
        if (($urandom_range(0, 3)) != 0) d = 8'($urandom_range(0, 6));
        step(1'b1, 1'b0, a, d, tk, "");
      end else if (op < 75) begin
        if (a == 2'd3) tag = "R10 random ctl";
        else if (m_lp[a]) tag = "R7 random snapshot";
        else if (m_acc[a] == 2'b11) tag = "R3 random pair";
        else tag = "R4 random single";
        step(1'b0, 1'b1, a, 8'h00, tk, tag);
      end else begin
        step(1'b0, 1'b0, 2'd0, 8'h00, tk, "");
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule